// File: doc/BRIEF.md
# Multi-Channel Register-Controlled PWM Bank

This block holds a configurable number of identical pulse-width outputs. Each output is set up through one 32-bit control word. A plain memory-mapped port reaches the control words: an address, a write strobe, write data and combinational read data. Each control word carries a run flag, a high-time count and a clock divider setting.

A running channel divides the input clock by (divider + 1) to form a tick. It then steps a position counter through a frame that is always 256 ticks long. The output is high while the position is below the high-time count, so software picks the frequency with the divider and the duty with the count.

A new setting written to a running channel is only copied into the live copy on the frame wrap, so a period is never cut short or stretched. Setting the run flag on an idle channel starts a fresh frame from position zero.

Top module: `pwm_bank`

## Requirements
- R1: After reset every control word reads 0x00000000 and every output is low.
- R2: Control word fields: bit 31 is the run flag, bits 24:16 hold a 9-bit high-time count, and bits 12:0 hold a 13-bit divider. A read returns the last written value masked to those fields (mask 0x81FF1FFF), and any other bit reads zero.
- R3: Channel k is at byte address 16·k. The channel index is taken from address bits [ADDR_W-1:4], and address bits 3:0 are ignored.
- R4: An address whose index is NUM_CH or above reads as zero, and a write to it changes no control word.
- R5: While the run flag is clear, the output is low and the divider and position counters sit at zero. The stored count and divider keep their values.
- R6: One tick lasts (divider+1) clocks and a frame lasts 256·(divider+1) clocks, so the output pattern repeats with that period.
- R7: In each frame the output is high for count·(divider+1) consecutive clocks starting at the frame's first clock, and low for the rest of the frame.
- R8: A count of 0 gives a constant-low output. A count of 256 or more gives a constant-high output.
- R9: Once a write sets the run flag on an idle channel, the output is high (when the count is nonzero) from the clock after the write edge, at the start of a new frame.
- R10: A count or divider written to a running channel takes effect only at the next frame wrap.
- R11: Writing all zeros stops the channel at once and clears its count and divider.
- R12: Channels run independently, and the setting of one does not change the waveform of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the control word |
| bus_wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pwm_out | output | NUM_CH | One pulse output per channel |

## Verification
The bench builds the block twice.

The first build uses NUM_CH=4 and ADDR_W=8. This leaves twelve unused index slots, which lets out-of-range reads and writes be checked next to live channels. It also lets two channels run at different dividers at the same time.

The second build uses NUM_CH=1 and shares the bus with the first. It shows that the single-channel build decodes only slot zero and treats the index-1 address as absent.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int REG_W      = 32;
  localparam int EN_BIT     = 31;
  localparam int FRAME_W    = 8;
  localparam int CNT_LSB    = 16;
  localparam int CNT_W      = FRAME_W + 1;
  localparam int DIV_W      = 13;
  localparam int STRIDE_LSB = 4;

  localparam logic [REG_W-1:0] REG_MASK =
      (32'h1 << EN_BIT) |
      (((32'h1 << CNT_W) - 32'h1) << CNT_LSB) |
      ((32'h1 << DIV_W) - 32'h1);

  typedef struct packed {
    logic             run;
    logic [CNT_W-1:0] count;
    logic [DIV_W-1:0] div;
  } chan_cfg_t;

  function automatic chan_cfg_t word_to_cfg(input logic [REG_W-1:0] w);
    chan_cfg_t c;
    c.run   = w[EN_BIT];
    c.count = w[CNT_LSB +: CNT_W];
    c.div   = w[DIV_W-1:0];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] cfg_to_word(input chan_cfg_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[EN_BIT]            = c.run;
    w[CNT_LSB +: CNT_W]  = c.count;
    w[DIV_W-1:0]         = c.div;
    return w;
  endfunction

  // High while the frame position is below the programmed count.
  function automatic logic level_at(input logic [CNT_W-1:0] count,
                                    input logic [FRAME_W-1:0] pos);
    return {1'b0, pos} < count;
  endfunction
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     wr_en,
  input  logic [REG_W-1:0]         wdata,
  output logic [REG_W-1:0]         rdata,
  output chan_cfg_t [NUM_CH-1:0]   cfg_o
);
  localparam int IDX_W = ADDR_W - STRIDE_LSB;

  logic [IDX_W-1:0]        idx;
  logic                    addr_hit;
  chan_cfg_t [NUM_CH-1:0]  cfg_q;

  assign idx      = addr[ADDR_W-1:STRIDE_LSB];
  assign addr_hit = {1'b0, idx} < (IDX_W+1)'(NUM_CH);
  assign cfg_o    = cfg_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cfg_q[c] <= '0;
      else if (wr_en && addr_hit && idx == IDX_W'(c))
        cfg_q[c] <= word_to_cfg(wdata);
    end
  end

  always_comb begin
    rdata = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (addr_hit && idx == IDX_W'(c))
        rdata = cfg_to_word(cfg_q[c]);
  end

  // R2
  unused_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & ~REG_MASK) == '0);
  // R4
  oor_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_hit |-> rdata == '0);
  // R4
  oor_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr_hit) |=> $stable(cfg_q));
endmodule

// File: rtl/pwm_prescale.sv
module pwm_prescale
  import pwm_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [DIV_W-1:0] div,
  output logic             tick,
  output logic [DIV_W-1:0] cnt
);
  assign tick = active && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!active)      cnt <= '0;
    else if (tick)         cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pwm_frame.sv
module pwm_frame
  import pwm_bank_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               active,
  input  logic               tick,
  input  logic [CNT_W-1:0]   new_count,
  input  logic [DIV_W-1:0]   new_div,
  output logic [FRAME_W-1:0] pos,
  output logic [CNT_W-1:0]   live_count,
  output logic [DIV_W-1:0]   live_div,
  output logic               wrap,
  output logic               level
);
  assign wrap  = tick && (pos == '1);
  assign level = level_at(live_count, pos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos        <= '0;
      live_count <= '0;
      live_div   <= '0;
    end else if (start) begin
      pos        <= '0;
      live_count <= new_count;
      live_div   <= new_div;
    end else if (!active) begin
      pos        <= '0;
    end else if (tick) begin
      pos <= pos + 1'b1;
      if (wrap) begin
        live_count <= new_count;
        live_div   <= new_div;
      end
    end
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_bank_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  chan_cfg_t cfg,
  output logic      pwm_o
);
  logic               run_q;
  logic               start;
  logic               active;
  logic               tick;
  logic               wrap;
  logic               level;
  logic [DIV_W-1:0]   pcnt;
  logic [FRAME_W-1:0] pos;
  logic [CNT_W-1:0]   live_count;
  logic [DIV_W-1:0]   live_div;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= cfg.run;
  end

  assign start  = cfg.run && !run_q;
  assign active = cfg.run && run_q;
  assign pwm_o  = active && level;

  pwm_prescale u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (active),
    .div    (live_div),
    .tick   (tick),
    .cnt    (pcnt)
  );

  pwm_frame u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .active     (active),
    .tick       (tick),
    .new_count  (cfg.count),
    .new_div    (cfg.div),
    .pos        (pos),
    .live_count (live_count),
    .live_div   (live_div),
    .wrap       (wrap),
    .level      (level)
  );

  // R5
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.run |-> !pwm_o);
  // R5
  off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.run |=> (pcnt == '0 && pos == '0));
  // R6
  pre_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> pcnt <= live_div);
  // R8
  full_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && live_count[CNT_W-1]) |-> pwm_o);
  // R9
  fresh_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> (pos == '0 && pcnt == '0));
  // R10
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !$past(wrap)) |->
      ($stable(live_count) && $stable(live_div)));
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  chan_cfg_t [NUM_CH-1:0] cfg;

  pwm_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (bus_addr),
    .wr_en (bus_wr_en),
    .wdata (bus_wdata),
    .rdata (bus_rdata),
    .cfg_o (cfg)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_channel u_ch (
      .clk   (clk),
      .rst_n (rst_n),
      .cfg   (cfg[c]),
      .pwm_o (pwm_out[c])
    );
  end
endmodule

// File: tb/pwm_bank_bench.sv
module pwm_bank_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr_en = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out;
  logic [31:0] one_rdata;
  logic [0:0]  one_out;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_bank #(.NUM_CH(4), .ADDR_W(8)) u_pwm_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out));

  pwm_bank #(.NUM_CH(1), .ADDR_W(8)) u_pwm_bank_one (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wdata(bus_wdata), .bus_rdata(one_rdata), .pwm_out(one_out));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic [31:0] d1);
    bus_addr = a;
    #1;
    d = bus_rdata;
    d1 = one_rdata;
  endtask

  task automatic count_high(input int ch, input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out[ch]) hi++;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d, d1;
    for (int c = 0; c < 4; c++) begin
      rd(8'(c << 4), d, d1);
      check("R1 word after reset", d, 32'h0);
    end
    check("R1 outputs after reset", {28'h0, pwm_out}, 32'h0);
  endtask

  task automatic t_fields();
    logic [31:0] d, d1;
    int hi;
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, d, d1);
    check("R2 masked readback", d, 32'h81FF_1FFF);
    count_high(1, 512, hi);
    check("R8 count 511 constant high", hi, 512);
    wr(8'h10, 32'h0);
    rd(8'h10, d, d1);
    check("R11 zero write clears word", d, 32'h0);
    count_high(1, 256, hi);
    check("R11 zero write stops output", hi, 0);
  endtask

  task automatic t_decode();
    logic [31:0] d, d1;
    wr(8'h2C, 32'h0005_0003);
    rd(8'h20, d, d1);
    check("R3 low address bits ignored on write", d, 32'h0005_0003);
    rd(8'h27, d, d1);
    check("R3 low address bits ignored on read", d, 32'h0005_0003);
    rd(8'h30, d, d1);
    check("R3 neighbour slot untouched", d, 32'h0);
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'hF0, 32'hFFFF_FFFF);
    rd(8'h40, d, d1);
    check("R4 out-of-range reads zero", d, 32'h0);
    rd(8'hF4, d, d1);
    check("R4 top slot reads zero", d, 32'h0);
    for (int c = 0; c < 4; c++) begin
      rd(8'(c << 4), d, d1);
      check("R4 write outside range ignored", d, (c == 2) ? 32'h0005_0003 : 32'h0);
    end
    repeat (4) @(negedge clk);
    check("R4 no channel started", {28'h0, pwm_out}, 32'h0);
    wr(8'h20, 32'h0);
  endtask

  task automatic t_wave();
    logic smp [0:799];
    int hi;
    wr(8'h00, 32'h8064_0002);
    for (int i = 0; i < 800; i++) begin
      @(negedge clk);
      smp[i] = pwm_out[0];
    end
    check("R9 high from first clock after start", {31'h0, smp[0]}, 32'h1);
    hi = 0;
    for (int i = 0; i < 768; i++) if (smp[i]) hi++;
    check("R7 high clocks per frame", hi, 300);
    hi = 0;
    for (int i = 0; i < 300; i++) if (smp[i]) hi++;
    check("R7 high run at frame start", hi, 300);
    check("R6 last clock of frame low", {31'h0, smp[767]}, 32'h0);
    check("R6 next frame after 768 clocks", {31'h0, smp[768]}, 32'h1);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_extremes();
    int hi;
    wr(8'h00, 32'h8000_0005);
    count_high(0, 1536, hi);
    check("R8 count 0 constant low", hi, 0);
    wr(8'h00, 32'h0);
    wr(8'h00, 32'h8100_0003);
    count_high(0, 1024, hi);
    check("R8 count 256 constant high", hi, 1024);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_update();
    logic [31:0] d, d1;
    int hi, wait_n;
    wr(8'h00, 32'h8040_0000);
    repeat (100) @(negedge clk);
    wr(8'h00, 32'h80C8_0000);
    rd(8'h00, d, d1);
    check("R2 readback shows new word at once", d, 32'h80C8_0000);
    count_high(0, 100, hi);
    check("R10 old count kept until wrap", hi, 0);
    wait_n = 0;
    while (!pwm_out[0] && wait_n < 300) begin
      @(negedge clk);
      wait_n++;
    end
    count_high(0, 255, hi);
    check("R10 new count after wrap", hi + 1, 200);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_disable();
    logic [31:0] d, d1;
    int hi;
    wr(8'h00, 32'h8040_0000);
    repeat (20) @(negedge clk);
    wr(8'h00, 32'h0040_0000);
    check("R5 output low right after clear", {31'h0, pwm_out[0]}, 32'h0);
    count_high(0, 300, hi);
    check("R5 output stays low", hi, 0);
    rd(8'h00, d, d1);
    check("R5 count retained while stopped", d, 32'h0040_0000);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_multi();
    int h1, h3, h0;
    wr(8'h10, 32'h8020_0000);
    wr(8'h30, 32'h8080_0001);
    h1 = 0; h3 = 0; h0 = 0;
    for (int i = 0; i < 512; i++) begin
      @(negedge clk);
      if (pwm_out[1]) h1++;
      if (pwm_out[3]) h3++;
      if (pwm_out[0] || pwm_out[2]) h0++;
    end
    check("R12 channel 1 count 32 divider 0", h1, 64);
    check("R12 channel 3 count 128 divider 1", h3, 256);
    check("R12 idle channels stay low", h0, 0);
    wr(8'h10, 32'h0);
    wr(8'h30, 32'h0);
  endtask

  task automatic t_single();
    logic [31:0] d, d1;
    int hi;
    wr(8'h10, 32'h8080_0000);
    rd(8'h10, d, d1);
    check("R4 single build: slot 1 absent", d1, 32'h0);
    rd(8'h00, d, d1);
    check("R4 single build: slot 0 untouched", d1, 32'h0);
    hi = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (one_out[0]) hi++;
    end
    check("R4 single build: output idle", hi, 0);
    wr(8'h10, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_decode();
    t_wave();
    t_extremes();
    t_update();
    t_disable();
    t_multi();
    t_single();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule